// File: doc/BRIEF.md
# Audio Serial Frame Transmitter

This block is the transmit side of a three-wire audio link and always acts as the clock master. It divides the system clock into two clocks. The first is an oversampled codec clock at 256 times the frame rate. The second is a bit clock, obtained from the codec clock by a fixed integer ratio. Each frame carries two channel slots of 32 bit clocks. The block drives a word-select (frame) line and a serial data line. The data line carries a left/right pair of 16-bit samples in one of four selectable framing standards: I2S (Philips), MSB-justified, LSB-justified and PCM short-frame.

Sample pairs arrive over a valid/ready handshake into a one-pair holding register. At the last system-clock cycle of every frame, the held pair moves into the active pair that the next frame transmits. If nothing is held at that moment, the block raises a one-cycle underrun pulse and sends a frame of zeros. The framing standard is read at the same frame boundary, so a change never splits a frame.

Top module: `audio_serial_tx`

## Requirements
- R1: The codec clock `mclk_o` toggles on every system clock (high on odd phase counts). The bit clock `bclk_o` has a period of 8 system clocks: low for 4, then high for 4. Both bit-clock edges fall on codec-clock falling edges. A frame is 64 bit clocks, which is 512 system clocks or 256 codec-clock periods.
- R2: `ws_o` and `sd_o` change only in the cycle where `bclk_o` falls. Each bit position is held for one full bit-clock period.
- R3: With `std_i`=0 (I2S), word select is high during bit positions 31 through 62 of the frame and low otherwise. The left sample goes out MSB first in positions 0 to 15. The right sample goes out in positions 32 to 47.
- R4: With `std_i`=1 (MSB-justified), word select is low for positions 0 to 31 and high for positions 32 to 63. The left sample goes out MSB first in positions 0 to 15. The right sample goes out in positions 32 to 47.
- R5: With `std_i`=2 (LSB-justified), word select follows the R4 pattern. The left sample goes out MSB first in positions 16 to 31 and the right sample in positions 48 to 63, so each LSB is the last bit of its slot.
- R6: With `std_i`=3 (PCM), word select is a one-bit-wide pulse at position 63, just before the data. The left sample goes out MSB first in positions 0 to 15 and the right sample in positions 16 to 31.
- R7: In every standard, `sd_o` is 0 at all bit positions that carry no sample bit.
- R8: `in_ready` is high exactly when the holding register is empty. A pair is taken when `in_valid` and `in_ready` are both high at a clock edge. The held pair becomes the transmitted pair at the last system clock of the frame and is sent in the following frame.
- R9: If the holding register is empty at the frame boundary, `underrun_o` is high for exactly one cycle after that edge and the next frame carries zeros. A pair offered in that same boundary cycle is still accepted and is sent in the frame after.
- R10: During and right after reset, all serial outputs are low, `in_ready` is high and `underrun_o` is low. The first frame carries zeros with I2S word-select timing.
- R11: `std_i` is sampled only at the frame boundary. A change in the middle of a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_i | input | 2 | Framing standard: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty, pair can be taken |
| in_left | input | 16 | Left-channel sample |
| in_right | input | 16 | Right-channel sample |
| mclk_o | output | 1 | Codec clock, 256 times the frame rate |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select / frame sync |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: no pair was ready at the frame boundary |

## Verification
The frame-boundary transfer and an input handshake can fall in the same clock edge. The harder case is when the holding register is empty, so the edge must both flag an underrun and accept the new pair for the frame after. The bench provokes this by watching its own model's phase and offering a pair exactly in the boundary cycle after a stall. It judges the result by the underrun pulse, by `in_ready` dropping, and by the zero frame followed by the offered samples. A second overlap comes from changing the framing standard in the middle of a frame while data keeps flowing. There, the per-cycle comparison shows that the old standard holds up to the boundary.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_MSBJ  = 2'd1,
    FMT_LSBJ  = 2'd2,
    FMT_PCM   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic used;
    logic right;
    int   idx;
  } pick_t;

  // Word-select level at frame bit position b.
  function automatic logic ws_level(fmt_e f, int b, int slot_w);
    int frame;
    frame = 2 * slot_w;
    case (f)
      FMT_I2S:  return (((b + 1) % frame) >= slot_w);
      FMT_MSBJ,
      FMT_LSBJ: return (b >= slot_w);
      default:  return (b == frame - 1);
    endcase
  endfunction

  // Which sample bit, if any, occupies frame bit position b.
  function automatic pick_t data_pick(fmt_e f, int b, int slot_w, int sample_w);
    pick_t p;
    int k;
    p.used  = 1'b0;
    p.right = (b >= slot_w);
    p.idx   = 0;
    k       = b % slot_w;
    case (f)
      FMT_I2S, FMT_MSBJ: begin
        p.used = (k < sample_w);
        p.idx  = sample_w - 1 - k;
      end
      FMT_LSBJ: begin
        p.used = (k >= slot_w - sample_w);
        p.idx  = slot_w - 1 - k;
      end
      default: begin
        p.right = (b >= sample_w);
        p.used  = (b < 2 * sample_w);
        p.idx   = (b < sample_w) ? (sample_w - 1 - b) : (2 * sample_w - 1 - b);
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ast_clkgen.sv
module ast_clkgen #(
  parameter int MCLK_HALF  = 1,
  parameter int BCLK_MCLK  = 4,
  parameter int FRAME_BITS = 64,
  parameter int BIT_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             mclk_nx,
  output logic             bclk_nx,
  output logic [BIT_W-1:0] bit_pos,
  output logic             frame_last
);
  localparam int BIT_HALF = MCLK_HALF * BCLK_MCLK;
  localparam int BIT_CLKS = 2 * BIT_HALF;
  localparam int SUB_W    = $clog2(BIT_CLKS);

  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bit_q;
  logic             sub_end;
  logic             bit_end;

  assign sub_end = (sub_q == SUB_W'(BIT_CLKS - 1));
  assign bit_end = (bit_q == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      bit_q <= '0;
    end else if (sub_end) begin
      sub_q <= '0;
      bit_q <= bit_end ? '0 : bit_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign bclk_nx    = (sub_q >= SUB_W'(BIT_HALF));
  assign bit_pos    = bit_q;
  assign frame_last = sub_end && bit_end;

  generate
    if (MCLK_HALF == 1) begin : g_mclk_fast
      assign mclk_nx = sub_q[0];
    end else begin : g_mclk_div
      localparam int MW = $clog2(2 * MCLK_HALF);
      logic [MW-1:0] m_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          m_q <= '0;
        else if (m_q == MW'(2 * MCLK_HALF - 1))
          m_q <= '0;
        else
          m_q <= m_q + 1'b1;
      end
      assign mclk_nx = (m_q >= MW'(MCLK_HALF));
    end
  endgenerate

endmodule

// File: rtl/ast_feed.sv
module ast_feed #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                frame_load,
  output logic                in_ready,
  output logic                pend_full,
  output logic [SAMPLE_W-1:0] act_left,
  output logic [SAMPLE_W-1:0] act_right,
  output logic                underrun_q
);
  logic [SAMPLE_W-1:0] pend_l_q, pend_r_q;
  logic                full_q;
  logic                take;

  assign take      = in_valid && !full_q;
  assign in_ready  = !full_q;
  assign pend_full = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      pend_l_q   <= '0;
      pend_r_q   <= '0;
      act_left   <= '0;
      act_right  <= '0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= frame_load && !full_q;
      if (frame_load) begin
        act_left  <= full_q ? pend_l_q : '0;
        act_right <= full_q ? pend_r_q : '0;
      end
      if (take) begin
        pend_l_q <= in_left;
        pend_r_q <= in_right;
        full_q   <= 1'b1;
      end else if (frame_load) begin
        full_q   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ast_framer.sv
module ast_framer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  parameter int BIT_W    = $clog2(2 * SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          std_i,
  input  logic                frame_load,
  input  logic [BIT_W-1:0]    bit_pos,
  input  logic [SAMPLE_W-1:0] act_left,
  input  logic [SAMPLE_W-1:0] act_right,
  output logic                ws_nx,
  output logic                sd_nx
);
  fmt_e                fmt_q;
  pick_t               pick;
  logic [SAMPLE_W-1:0] word;
  int                  b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fmt_q <= FMT_I2S;
    else if (frame_load)
      fmt_q <= fmt_e'(std_i);
  end

  always_comb begin
    b     = int'(bit_pos);
    ws_nx = ws_level(fmt_q, b, SLOT_W);
    pick  = data_pick(fmt_q, b, SLOT_W, SAMPLE_W);
    word  = pick.right ? act_right : act_left;
    sd_nx = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (pick.used && (pick.idx == i))
        sd_nx = word[i];
    end
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int SAMPLE_W   = 16,
  parameter int SLOT_W     = 32,
  parameter int MCLK_RATIO = 256,
  parameter int MCLK_HALF  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          std_i,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int BCLK_MCLK  = MCLK_RATIO / FRAME_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  generate
    if ((MCLK_RATIO % FRAME_BITS) != 0 || (BCLK_MCLK % 2) != 0 || SAMPLE_W > SLOT_W)
      $error("audio_serial_tx: unsupported parameter combination");
  endgenerate

  logic             mclk_nx, bclk_nx, ws_nx, sd_nx;
  logic [BIT_W-1:0] bit_pos;
  logic             frame_load;
  logic             pend_full;
  logic [SAMPLE_W-1:0] act_left, act_right;

  ast_clkgen #(
    .MCLK_HALF (MCLK_HALF),
    .BCLK_MCLK (BCLK_MCLK),
    .FRAME_BITS(FRAME_BITS),
    .BIT_W     (BIT_W)
  ) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclk_nx   (mclk_nx),
    .bclk_nx   (bclk_nx),
    .bit_pos   (bit_pos),
    .frame_last(frame_load)
  );

  ast_feed #(.SAMPLE_W(SAMPLE_W)) u_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .frame_load(frame_load),
    .in_ready  (in_ready),
    .pend_full (pend_full),
    .act_left  (act_left),
    .act_right (act_right),
    .underrun_q(underrun_o)
  );

  ast_framer #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W),
    .BIT_W   (BIT_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .std_i     (std_i),
    .frame_load(frame_load),
    .bit_pos   (bit_pos),
    .act_left  (act_left),
    .act_right (act_right),
    .ws_nx     (ws_nx),
    .sd_nx     (sd_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_o <= 1'b0;
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      mclk_o <= mclk_nx;
      bclk_o <= bclk_nx;
      ws_o   <= ws_nx;
      sd_o   <= sd_nx;
    end
  end

endmodule

// File: rtl/ast_checker.sv
module ast_checker #(
  parameter int FRAME_CLK = 512
) (
  input logic clk,
  input logic rst_n,
  input logic mclk_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o,
  input logic in_ready,
  input logic underrun_o,
  input logic frame_load,
  input logic pend_full
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_load) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_bclk_on_mclk_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bclk_o) || $fell(bclk_o)) |-> $fell(mclk_o));

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && seen_q) |-> (gap_q == 16'(FRAME_CLK - 1)));

  assert_ws_on_bclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk_o) |-> $stable(ws_o));

  assert_sd_on_bclk_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bclk_o) |-> $stable(sd_o));

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_full |-> !in_ready);

  assert_underrun_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_load && !pend_full) |=> underrun_o);

  assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o);

endmodule

bind audio_serial_tx ast_checker #(
  .FRAME_CLK(2 * SLOT_W * 2 * MCLK_HALF * (MCLK_RATIO / (2 * SLOT_W)))
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mclk_o    (mclk_o),
  .bclk_o    (bclk_o),
  .ws_o      (ws_o),
  .sd_o      (sd_o),
  .in_ready  (in_ready),
  .underrun_o(underrun_o),
  .frame_load(frame_load),
  .pend_full (pend_full)
);

// File: tb/audio_serial_tx_tb.sv
`timescale 1ns/1ps
module audio_serial_tx_tb;
  localparam int FR   = 512;   // system clocks per frame
  localparam int BITC = 8;     // system clocks per bit

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  std_i = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0, in_right = '0;
  logic        mclk_o, bclk_o, ws_o, sd_o, underrun_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  audio_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .std_i(std_i),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .underrun_o(underrun_o)
  );

  // ---------------- behavioural reference model ----------------
  int          mp;          // phase of the upcoming edge
  int          mstd;        // standard of the frame in flight
  logic [15:0] ml, mr;      // pair in flight
  logic [31:0] mq[$];       // holding register, at most one entry
  logic e_mclk, e_bclk, e_ws, e_sd, e_ready, e_und;
  string tag;

  function automatic logic exp_ws(int s, int b);
    if (s == 0) return (b >= 31 && b < 63);
    if (s == 3) return (b == 63);
    return (b >= 32);
  endfunction

  // data start positions of the two channels in each standard
  function automatic int start_of(int s, bit right);
    int starts[4][2] = '{'{0, 32}, '{0, 32}, '{16, 48}, '{0, 16}};
    return starts[s][right];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 0; mstd = 0; ml = '0; mr = '0; mq.delete();
      e_mclk = 0; e_bclk = 0; e_ws = 0; e_sd = 0; e_ready = 1; e_und = 0;
      tag = "R3";
    end else begin
      int b, sl, sr;
      bit acc;
      b      = mp / BITC;
      e_mclk = mp % 2;
      e_bclk = (mp % BITC) >= BITC / 2;
      e_ws   = exp_ws(mstd, b);
      sl     = start_of(mstd, 0);
      sr     = start_of(mstd, 1);
      e_sd   = 0;
      if (b >= sl && b < sl + 16) e_sd = ml[15 - (b - sl)];
      else if (b >= sr && b < sr + 16) e_sd = mr[15 - (b - sr)];
      case (mstd)
        0: tag = "R3";
        1: tag = "R4";
        2: tag = "R5";
        default: tag = "R6";
      endcase
      if (!((b >= sl && b < sl + 16) || (b >= sr && b < sr + 16)))
        tag = {tag, " R7"};
      acc   = in_valid && (mq.size() == 0);
      e_und = (mp == FR - 1) && (mq.size() == 0);
      if (mp == FR - 1) begin
        if (mq.size() != 0) begin
          logic [31:0] w;
          w = mq.pop_front();
          ml = w[31:16]; mr = w[15:0];
        end else begin
          ml = '0; mr = '0;
        end
        mstd = int'(std_i);   // R11: standard taken only here
      end
      if (acc) mq.push_back({in_left, in_right});
      e_ready = (mq.size() == 0);
      mp = (mp + 1) % FR;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      bad = 0;
      n_cmp++;
      if (mclk_o !== e_mclk || bclk_o !== e_bclk) begin
        bad = 1;
        $display("FAIL R1 clocks: mclk=%b bclk=%b expected mclk=%b bclk=%b", mclk_o, bclk_o, e_mclk, e_bclk);
      end
      if (ws_o !== e_ws) begin
        bad = 1;
        $display("FAIL R2 %s ws: actual %b expected %b (phase %0d)", tag, ws_o, e_ws, mp);
      end
      if (sd_o !== e_sd) begin
        bad = 1;
        $display("FAIL R2 %s sd: actual %b expected %b (phase %0d)", tag, sd_o, e_sd, mp);
      end
      if (in_ready !== e_ready) begin
        bad = 1;
        $display("FAIL R8 ready: actual %b expected %b", in_ready, e_ready);
      end
      if (underrun_o !== e_und) begin
        bad = 1;
        $display("FAIL R9 underrun: actual %b expected %b", underrun_o, e_und);
      end
      if (bad) n_bad++;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    wait_clks(4);
    // R10: reset state
    check("R10 mclk", mclk_o, 1'b0);
    check("R10 bclk", bclk_o, 1'b0);
    check("R10 ws", ws_o, 1'b0);
    check("R10 sd", sd_o, 1'b0);
    check("R10 ready", in_ready, 1'b1);
    check("R10 underrun", underrun_o, 1'b0);
    rst_n = 1'b1;

    fork
      begin
        send_pair(16'hA5C3, 16'h0F0F);
        send_pair(16'h8001, 16'h7FFE);
        send_pair(16'hFFFF, 16'h0000);
        send_pair(16'h1234, 16'hFEDC);
        send_pair(16'hC001, 16'h8003);
        send_pair(16'h5A5A, 16'hA5A5);
        send_pair(16'h0001, 16'h8000);
        send_pair(16'hBEEF, 16'hCAFE);
        send_pair(16'h3C3C, 16'hE71D);
        send_pair(16'h9669, 16'h6996);
      end
      begin
        // R11: every switch lands mid-frame
        wait_clks(2 * FR + 200); std_i = 2'd1;
        wait_clks(2 * FR);       std_i = 2'd2;
        wait_clks(2 * FR);       std_i = 2'd3;
        wait_clks(2 * FR);       std_i = 2'd0;
      end
    join

    // R9: stall so that at least two frames underrun and carry zeros
    std_i = 2'd2;
    wait_clks(3 * FR);

    // R9 + R8: offer a pair exactly in the boundary cycle with an empty holder
    while (!(mp == FR - 1 && mq.size() == 0)) @(negedge clk);
    in_valid = 1'b1; in_left = 16'hD00D; in_right = 16'h2BAD;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 underrun on boundary offer", underrun_o, 1'b1);
    check("R8 pair taken on boundary", in_ready, 1'b0);
    @(negedge clk);
    check("R9 underrun lasts one cycle", underrun_o, 1'b0);
    std_i = 2'd3;
    wait_clks(2 * FR + 20);
    check("R8 holder empty again", in_ready, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule